// File: doc/BRIEF.md
# Clock Source Selector with Guarded Register Writes and Divided Tick

This block manages the operating clock of a small processor core inside one synchronous clock domain. Two oscillators are modelled only by per-cycle "running" strobes. The block keeps a 4-bit mode register that software can write and read back. Two bits of that register pick a division ratio, one bit stops the main oscillator, and one bit chooses the source. A separate 1-bit control register stops the on-chip oscillator and can only be written. Because the block makes a clock-enable tick and does not gate a clock, it never produces a glitched clock.

Writes to the source bits are checked before they take effect. A write is refused, and a sticky error flag is set, if it would stop the oscillator in use, select an oscillator that is stopped or locked out, land on the "main selected but stopped" code, or jump straight between "main only" and "on-chip only" without passing through the middle setting. The division bits of a mode write are always taken. The source bits are held in a state machine whose three states match the three legal codes:

- **ST_MAIN** (code 00): main oscillator selected and running.
- **ST_ONCHIP_BOTH** (code 01): on-chip oscillator selected, main still enabled. This is the reset state.
- **ST_ONCHIP_ONLY** (code 11): on-chip oscillator selected, main stopped.

The state machine allows four transitions:

- **GO_ONCHIP**: ST_MAIN to ST_ONCHIP_BOTH. It needs the on-chip oscillator enabled and the lock input low.
- **GO_MAIN**: ST_ONCHIP_BOTH to ST_MAIN.
- **STOP_MAIN**: ST_ONCHIP_BOTH to ST_ONCHIP_ONLY.
- **START_MAIN**: ST_ONCHIP_ONLY to ST_ONCHIP_BOTH.

A write of the code the state already holds changes nothing and flags nothing.

Top module: `clkctl_top`

## Requirements
- R1: After reset, rd_data reads 4'b1101 (divide by 8, main enabled, on-chip selected), onchip_en=1, main_en=1, src_sel=1, err=0 and tick=0.
- R2: A write with wr_addr=0 always loads wr_data[3:2] into the division field (rd_data[3:2]), even when the source bits of the same write are refused.
- R3: The source bits (rd_data[1:0]) change only along 00→01, 01→00, 01→11 and 11→01. Writing the current code changes nothing and does not set err.
- R4: A write that asks for 00→11 or 11→00 is refused. The source bits keep their value and err is set.
- R5: The code 10 is never accepted into the source bits. A write asking for it sets err.
- R6: A write with wr_addr=1 loads wr_data[0] into the on-chip stop bit (onchip_en = not that bit). A write that sets the bit while the on-chip source is selected is refused and sets err. The move 00→01 is refused and sets err while the on-chip oscillator is stopped.
- R7: While onchip_lock is high, the move 00→01 is refused and sets err.
- R8: err rises on the clock edge that handles a refused write and then stays high until reset.
- R9: tick is high for one cycle, one clock after every Nth active cycle of the selected source, where N is 1, 2, 4 or 8 for division codes 00, 01, 10 and 11.
- R10: A new division code takes effect only at a tick boundary. The period in progress finishes with the old ratio.
- R11: An active cycle is a cycle with the selected source's run strobe high and that source not stopped. The run strobe of the unselected source has no effect on tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the mode register, 1 selects the on-chip control register |
| wr_data | input | 4 | Write data |
| main_run | input | 1 | Main oscillator cycle strobe |
| onchip_run | input | 1 | On-chip oscillator cycle strobe |
| onchip_lock | input | 1 | Configuration input that forbids selecting the on-chip oscillator |
| rd_data | output | 4 | Mode register read-back |
| main_en | output | 1 | Main oscillator enable |
| onchip_en | output | 1 | On-chip oscillator enable |
| src_sel | output | 1 | 1 when the on-chip source is selected |
| err | output | 1 | Sticky refused-write flag |
| tick | output | 1 | Divided clock-enable pulse |

## Verification
If the selector state machine took a wrong transition, the next clock would show it in rd_data[1:0] and src_sel, and also in err when a refusal was missed or raised in error. A corrupt prescaler count or a division ratio latched too early shows up as a tick one or more active cycles out of place, at the latest within eight active cycles. The bench runs a reference model next to the design and compares every output at every cycle, so each of these faults is reported in the cycle it first shows.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
    localparam int DIV_W = 2;
    localparam int SRC_W = 2;
    localparam int MODE_W = DIV_W + SRC_W;

    typedef enum logic [SRC_W-1:0] {
        ST_MAIN        = 2'b00,
        ST_ONCHIP_BOTH = 2'b01,
        ST_ONCHIP_ONLY = 2'b11
    } sel_state_t;

    localparam sel_state_t SEL_RESET = ST_ONCHIP_BOTH;
    localparam logic [DIV_W-1:0] DIV_RESET = '1;
endpackage

// File: rtl/clkctl_sel_fsm.sv
module clkctl_sel_fsm
    import clkctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_mode,
    input  logic [SRC_W-1:0] wr_code,
    input  logic             onchip_stopped,
    input  logic             onchip_lock,
    output logic [SRC_W-1:0] code,
    output logic             refused
);
    sel_state_t state_q, state_d;
    logic       move_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEL_RESET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        move_ok = 1'b0;
        if (wr_mode) begin
            unique case (state_q)
                ST_MAIN: begin
                    if (wr_code == ST_ONCHIP_BOTH && !onchip_stopped && !onchip_lock) begin
                        state_d = ST_ONCHIP_BOTH;   // GO_ONCHIP
                        move_ok = 1'b1;
                    end
                end
                ST_ONCHIP_BOTH: begin
                    if (wr_code == ST_MAIN) begin
                        state_d = ST_MAIN;          // GO_MAIN
                        move_ok = 1'b1;
                    end else if (wr_code == ST_ONCHIP_ONLY) begin
                        state_d = ST_ONCHIP_ONLY;   // STOP_MAIN
                        move_ok = 1'b1;
                    end
                end
                ST_ONCHIP_ONLY: begin
                    if (wr_code == ST_ONCHIP_BOTH) begin
                        state_d = ST_ONCHIP_BOTH;   // START_MAIN
                        move_ok = 1'b1;
                    end
                end
                default: begin
                    state_d = SEL_RESET;
                end
            endcase
        end
    end

    always_comb begin
        code    = state_q;
        refused = wr_mode && (wr_code != state_q) && !move_ok;
    end
endmodule

// File: rtl/clkctl_prescaler.sv
module clkctl_prescaler
    import clkctl_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_act,
    input  logic [DW-1:0] div_req,
    output logic [DW-1:0] div_act,
    output logic          tick
);
    localparam int CNT_W = (1 << DW) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             wrap;

    always_comb begin
        limit = CNT_W'((1 << div_act) - 1);
        wrap  = src_act && (cnt_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            div_act <= DW'((1 << DW) - 1);
            tick    <= 1'b0;
        end else begin
            tick <= wrap;
            if (wrap) begin
                cnt_q   <= '0;
                div_act <= div_req;
            end else if (src_act) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
    import clkctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [MODE_W-1:0] wr_data,
    input  logic              main_run,
    input  logic              onchip_run,
    input  logic              onchip_lock,
    output logic [MODE_W-1:0] rd_data,
    output logic              main_en,
    output logic              onchip_en,
    output logic              src_sel,
    output logic              err,
    output logic              tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_act;
    logic [SRC_W-1:0] mode_lo;
    logic             osc_stop_q;
    logic             wr_mode, wr_ctrl;
    logic             rej_mode, rej_ctrl;
    logic             src_act;

    assign wr_mode = wr_en && !wr_addr;
    assign wr_ctrl = wr_en && wr_addr;

    clkctl_sel_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_mode        (wr_mode),
        .wr_code        (wr_data[SRC_W-1:0]),
        .onchip_stopped (osc_stop_q),
        .onchip_lock    (onchip_lock),
        .code           (mode_lo),
        .refused        (rej_mode)
    );

    assign rej_ctrl = wr_ctrl && wr_data[0] && mode_lo[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q      <= DIV_RESET;
            osc_stop_q <= 1'b0;
            err        <= 1'b0;
        end else begin
            if (wr_mode) div_q <= wr_data[MODE_W-1:SRC_W];
            if (wr_ctrl && !rej_ctrl) osc_stop_q <= wr_data[0];
            if (rej_mode || rej_ctrl) err <= 1'b1;
        end
    end

    always_comb begin
        src_act = mode_lo[0] ? (onchip_run && !osc_stop_q)
                             : (main_run && !mode_lo[1]);
    end

    clkctl_prescaler #(.DW(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_act (src_act),
        .div_req (div_q),
        .div_act (div_act),
        .tick    (tick)
    );

    assign rd_data   = {div_q, mode_lo};
    assign main_en   = !mode_lo[1];
    assign onchip_en = !osc_stop_q;
    assign src_sel   = mode_lo[0];
endmodule

// File: rtl/clkctl_sva.sv
module clkctl_sva (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] lo,
    input logic       err,
    input logic       tick,
    input logic       osc_stop,
    input logic       lock,
    input logic       src_act,
    input logic [1:0] div_act
);
    p_no_code10_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lo != 2'b10);

    p_no_jump_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lo == 2'b00) |=> (lo != 2'b11));

    p_no_jump_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lo == 2'b11) |=> (lo != 2'b00));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    p_sel_running_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lo[0] |-> !osc_stop);

    p_lock_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !lo[0]) |=> !lo[0]);

    p_tick_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(src_act));

    p_div_at_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_act) |-> tick);
endmodule

bind clkctl_top clkctl_sva u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .lo       (mode_lo),
    .err      (err),
    .tick     (tick),
    .osc_stop (osc_stop_q),
    .lock     (onchip_lock),
    .src_act  (src_act),
    .div_act  (div_act)
);

// File: tb/test_clkctl_top.sv
module test_clkctl_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_addr = 1'b0;
    logic [3:0] wr_data = '0;
    logic main_run = 1'b0, onchip_run = 1'b0, onchip_lock = 1'b0;
    logic [3:0] rd_data;
    logic main_en, onchip_en, src_sel, err, tick;

    int checks = 0, errors = 0;
    bit finished = 0;

    int m_lo, m_div, m_ctrl, m_err, m_cnt, m_dact, m_tick;

    always #2 clk = ~clk;

    clkctl_top i_clkctl_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .main_run(main_run), .onchip_run(onchip_run),
        .onchip_lock(onchip_lock), .rd_data(rd_data), .main_en(main_en),
        .onchip_en(onchip_en), .src_sel(src_sel), .err(err), .tick(tick)
    );

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lo = 1; m_div = 3; m_ctrl = 0; m_err = 0;
            m_cnt = 0; m_dact = 3; m_tick = 0;
        end else begin
            int active, nl;
            bit ok;
            if (m_lo % 2 == 1) active = (onchip_run && m_ctrl == 0) ? 1 : 0;
            else               active = (main_run && m_lo < 2) ? 1 : 0;
            m_tick = 0;
            if (active == 1) begin
                if (m_cnt == (2 ** m_dact) - 1) begin
                    m_cnt = 0; m_dact = m_div; m_tick = 1;
                end else m_cnt = m_cnt + 1;
            end
            if (wr_en && !wr_addr) begin
                m_div = wr_data / 4;
                nl = wr_data % 4;
                if (nl != m_lo) begin
                    ok = (m_lo == 1 && (nl == 0 || nl == 3)) ||
                         (m_lo == 3 && nl == 1) ||
                         (m_lo == 0 && nl == 1 && m_ctrl == 0 && !onchip_lock);
                    if (ok) m_lo = nl; else m_err = 1;
                end
            end else if (wr_en && wr_addr) begin
                if (wr_data[0] && (m_lo % 2 == 1)) m_err = 1;
                else m_ctrl = wr_data[0];
            end
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, at the falling edge
    task automatic compare_all();
        chk(rd_data[3:2], m_div, "R2 division field");
        chk(rd_data[1:0], m_lo, "R3 source bits");
        chk(src_sel, m_lo % 2, "R3 src_sel");
        chk(main_en, (m_lo < 2) ? 1 : 0, "R3 main_en");
        chk(onchip_en, 1 - m_ctrl, "R6 onchip_en");
        chk(err, m_err, "R8 error flag");
        chk(tick, m_tick, "R9/R10/R11 tick");
    endtask

    task automatic step(input bit we, input bit a, input int d);
        @(negedge clk);
        compare_all();
        wr_en = we; wr_addr = a; wr_data = d[3:0];
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; wr_en = 0;
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(rd_data, 13, "R1 mode reset");
        chk(onchip_en, 1, "R1 onchip_en");
        chk(main_en, 1, "R1 main_en");
        chk(src_sel, 1, "R1 src_sel");
        chk(err, 0, "R1 err");
        chk(tick, 0, "R1 tick");

        // R9: divide by 8 on on-chip source, then through mode
        onchip_run = 1;
        idle(20);
        step(1, 0, 4'b0001); idle(12);
        // R11: main strobe must not count while on-chip selected
        onchip_run = 0; main_run = 1; idle(6);
        chk(tick, 0, "R11 unselected strobe ignored");
        onchip_run = 1; main_run = 0;
        // R10: change from divide 8 to through in mid period
        step(1, 0, 4'b1101); idle(3);
        step(1, 0, 4'b0001); idle(12);
        // R3 to ST_ONCHIP_ONLY, R4 jump down refused, R2 div taken
        step(1, 0, 4'b0111); idle(2);
        step(1, 0, 4'b1000); idle(1);
        chk(rd_data, 4'b1011, "R4 refused jump keeps source, R2 div taken");
        chk(err, 1, "R4 err set");
        idle(4);
        chk(err, 1, "R8 err sticky");
        do_reset();
        // R5 code 10 refused
        step(1, 0, 4'b0010); idle(1);
        chk(rd_data[1:0], 1, "R5 code 10 refused");
        chk(err, 1, "R5 err");
        do_reset();
        // to main, stop on-chip, try to select it
        main_run = 1;
        step(1, 0, 4'b0100); idle(1);
        chk(rd_data[1:0], 0, "R3 GO_MAIN");
        step(1, 1, 4'b0001); idle(1);
        chk(onchip_en, 0, "R6 stop accepted while main selected");
        step(1, 0, 4'b0011); idle(1);
        chk(rd_data[1:0], 0, "R4 jump up refused");
        do_reset();
        main_run = 1;
        step(1, 0, 4'b0100); step(1, 1, 4'b0001);
        step(1, 0, 4'b0101); idle(1);
        chk(rd_data[1:0], 0, "R6 stopped on-chip not selectable");
        chk(err, 1, "R6 err");
        do_reset();
        step(1, 0, 4'b0100);
        onchip_lock = 1;
        step(1, 0, 4'b0101); idle(1);
        chk(rd_data[1:0], 0, "R7 lock refuses on-chip");
        onchip_lock = 0;
        do_reset();
        step(1, 1, 4'b0001); idle(1);
        chk(onchip_en, 1, "R6 stop refused while on-chip selected");
        chk(err, 1, "R6 err on control write");
        do_reset();
        step(1, 0, 4'b0101); idle(1);
        chk(err, 0, "R3 same code no error");

        // random phase
        for (int i = 0; i < 6000; i++) begin
            main_run = $urandom_range(0, 3) != 0;
            onchip_run = $urandom_range(0, 2) != 0;
            onchip_lock = $urandom_range(0, 7) == 0;
            if ($urandom_range(0, 400) == 0) do_reset();
            else if ($urandom_range(0, 5) == 0)
                step(1, $urandom_range(0, 4) == 0, $urandom_range(0, 15));
            else step(0, 0, 0);
        end
        idle(2);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule